// File: doc/BRIEF.md
# Stereo Pair Configuration Sequencer

This block is a host-side controller that brings two image sensors up so that they run in lockstep. After a `start` pulse it works through a fixed program of register accesses. It hands each access, one at a time, to a generic two-wire command engine through a valid/ready request, and it waits for that engine's `cmd_done` pulse before it moves on. The request carries a device address, a register number, write data and a read flag.

Each sensor has one address bit that the host controls. The sequencer drives one select line per sensor. When both lines are low, a single bus transaction reaches both sensors. When the lines are opposite, only one sensor answers.

The program has three parts. First it powers up the links and the clocking, and it writes a table of broadcast settings such as resolution, blanking and exposure. Then it runs a tuning loop: it writes one skew setting to the master, reads the lockstep error registers of both sensors, and soft-resets both sensors. If any read reports a mismatch, the loop runs again with the next skew entry. The sequencer finishes with `done` when a pass comes back clean, or with `fail` once the retry budget is spent.

Top module: `stereo_cfg_seq`

## Requirements
- R1: After reset, `cmd_valid`, `busy`, `done` and `fail` are low and `{sel_m,sel_s}` is `2'b11`. The select lines return to `2'b11` whenever no command is pending.
- R2: The select lines are held for the whole life of a command. The encoding of `{sel_m,sel_s}` is: `2'b00` broadcast to both sensors, `2'b01` master only, `2'b10` slave only. `cmd_addr` always carries the `DEV_ADDR` parameter.
- R3: A read (`cmd_rd`=1) is never broadcast. It always uses `2'b01` or `2'b10`, and its `cmd_wdata` is 0.
- R4: The bring-up writes come in this order, with B1, S07, L2, L3 the base-value parameters of registers 0xB1, 0x07, 0xB2 and 0xB3:
  - broadcast 0xB1 = B1&~3
  - master 0xB1 = (B1&~3)|1
  - broadcast 0x07 = (S07&~0x60)|0x20
  - the extra table
  - broadcast 0xB3 = L3&~0x10
  - broadcast 0xB2 = L2&~0x10
  - master 0xB1 = (B1&~3)|1
  - slave 0xB1 = B1&~3
  - slave 0x07 = S07|0x60
- R5: Each extra-table entry i is the 24-bit field `EXTRA_TAB[24i+23:24i]`, holding {register[23:16], data[15:0]}. The entries are written as broadcasts in ascending i, right after the write to register 0x07.
- R6: Only one command is outstanding at a time. `cmd_valid` stays low from the accepting handshake until the matching `cmd_done`, and the next request starts only after that.
- R7: While `cmd_valid` is high and `cmd_ready` is low, the request and all its fields are held unchanged.
- R8: Pass p (counting from 0) uses skew entry e = `SKEW_TAB[8j+7:8j]` with j = p mod `NUM_SKEW`. It writes to the master only, in this order:
  - 0xB2 = (L2&~0x17)|e[2:0]
  - 0xB3 = (L3&~0x17)|e[5:3]
  - 0xB4 = (L4&~3)|e[7:6]
- R9: After the tuning writes, the block reads master 0xB7, master 0xB8, slave 0xB7 and slave 0xB8. The pass counts as a mismatch if bit `FLAG_BIT` of any of the four read words is 1.
- R10: Each pass ends with a broadcast of 0x0C = 1 followed by a broadcast of 0x0C = 0.
- R11: If a pass shows no mismatch, `done` rises and stays high, with `busy` low and no further request, until the next `start`. If a pass shows a mismatch, the next pass begins with the tuning writes.
- R12: If `MAX_TRIES` passes in a row show a mismatch, `fail` rises and stays high, with no further request, until the next `start`. `done` and `fail` are never high together.
- R13: `start` is ignored while `busy` is high. It is accepted from idle, done or fail, and each accepted start restarts the program at its first write with pass 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the configuration program |
| cmd_valid | output | 1 | Request to the two-wire engine |
| cmd_ready | input | 1 | Engine accepts the request |
| cmd_addr | output | 7 | Device address of the transaction |
| cmd_reg | output | 8 | Register number |
| cmd_wdata | output | 16 | Write data (0 for reads) |
| cmd_rd | output | 1 | 1 = read, 0 = write |
| cmd_done | input | 1 | One-cycle pulse: the accepted command has finished |
| cmd_rdata | input | 16 | Read data, valid with `cmd_done` |
| sel_m | output | 1 | Host-controlled address bit of the master sensor |
| sel_s | output | 1 | Host-controlled address bit of the slave sensor |
| busy | output | 1 | Program in progress |
| done | output | 1 | Lockstep reached |
| fail | output | 1 | Retry budget exhausted |

## Verification
The hardest state to reach is a retry budget that runs out exactly on the last permitted pass. Reaching it also exercises the wrap of the skew index past the end of its table. The stimulus gets there by sweeping the number of failing passes from zero to `MAX_TRIES` with a three-entry skew table, so the index wraps before the budget ends. The failing read moves among all four feedback reads from pass to pass, so every read position is shown to be able to trigger a retry. Handshake latencies vary per command. In one run `start` is pulsed in the middle of the program to show that it is ignored.

// File: rtl/stereo_cfg_pkg.sv
package stereo_cfg_pkg;

  typedef enum logic [1:0] {
    TGT_BOTH   = 2'd0,
    TGT_MASTER = 2'd1,
    TGT_SLAVE  = 2'd2
  } tgt_e;

  typedef struct packed {
    tgt_e        tgt;
    logic        rd;
    logic [7:0]  regno;
    logic [15:0] data;
  } cmd_t;

  localparam logic [7:0] REG_CTRL   = 8'h07;
  localparam logic [7:0] REG_RESET  = 8'h0C;
  localparam logic [7:0] REG_LINK   = 8'hB1;
  localparam logic [7:0] REG_RXCFG  = 8'hB2;
  localparam logic [7:0] REG_TXCFG  = 8'hB3;
  localparam logic [7:0] REG_SHIFT  = 8'hB4;
  localparam logic [7:0] REG_ERR_A  = 8'hB7;
  localparam logic [7:0] REG_ERR_B  = 8'hB8;

  localparam logic [1:0] SEL_IDLE   = 2'b11;

endpackage

// File: rtl/stereo_cfg_rom.sv
module stereo_cfg_rom
  import stereo_cfg_pkg::*;
#(
  parameter int NUM_EXTRA = 4,
  parameter int NUM_SKEW  = 4,
  parameter int PC_W      = 5,
  parameter int SK_W      = 2,
  parameter logic [NUM_EXTRA*24-1:0] EXTRA_TAB = '0,
  parameter logic [NUM_SKEW*8-1:0]   SKEW_TAB  = '0,
  parameter logic [15:0] B1_BASE  = 16'h0000,
  parameter logic [15:0] S07_BASE = 16'h0000,
  parameter logic [15:0] L2_BASE  = 16'h0000,
  parameter logic [15:0] L3_BASE  = 16'h0000,
  parameter logic [15:0] L4_BASE  = 16'h0000
) (
  input  logic [PC_W-1:0] pc,
  input  logic [SK_W-1:0] skew_idx,
  output cmd_t            cmd
);

  localparam logic [PC_W-1:0] PC_EXT0 = PC_W'(3);
  localparam logic [PC_W-1:0] PC_TAIL = PC_W'(3 + NUM_EXTRA);

  localparam logic [15:0] LINK_ON   = B1_BASE & ~16'h0003;
  localparam logic [15:0] LINK_BYP  = (B1_BASE & ~16'h0003) | 16'h0001;
  localparam logic [15:0] CTRL_PAIR = (S07_BASE & ~16'h0060) | 16'h0020;
  localparam logic [15:0] CTRL_SLV  = S07_BASE | 16'h0060;

  logic [7:0]      skew;
  logic [PC_W-1:0] off;
  int              ei;

  always_comb begin
    skew = SKEW_TAB[int'(skew_idx)*8 +: 8];
    off  = pc - PC_TAIL;
    ei   = int'(pc) - 3;
    cmd  = '{tgt: TGT_BOTH, rd: 1'b0, regno: 8'h00, data: 16'h0000};
    if (pc < PC_EXT0) begin
      unique case (pc[1:0])
        2'd0:    cmd = '{tgt: TGT_BOTH,   rd: 1'b0, regno: REG_LINK, data: LINK_ON};
        2'd1:    cmd = '{tgt: TGT_MASTER, rd: 1'b0, regno: REG_LINK, data: LINK_BYP};
        default: cmd = '{tgt: TGT_BOTH,   rd: 1'b0, regno: REG_CTRL, data: CTRL_PAIR};
      endcase
    end else if (pc < PC_TAIL) begin
      cmd.tgt   = TGT_BOTH;
      cmd.rd    = 1'b0;
      cmd.regno = EXTRA_TAB[ei*24+16 +: 8];
      cmd.data  = EXTRA_TAB[ei*24 +: 16];
    end else begin
      case (off)
        PC_W'(0):  cmd = '{tgt: TGT_BOTH,   rd: 1'b0, regno: REG_TXCFG, data: L3_BASE & ~16'h0010};
        PC_W'(1):  cmd = '{tgt: TGT_BOTH,   rd: 1'b0, regno: REG_RXCFG, data: L2_BASE & ~16'h0010};
        PC_W'(2):  cmd = '{tgt: TGT_MASTER, rd: 1'b0, regno: REG_LINK,  data: LINK_BYP};
        PC_W'(3):  cmd = '{tgt: TGT_SLAVE,  rd: 1'b0, regno: REG_LINK,  data: LINK_ON};
        PC_W'(4):  cmd = '{tgt: TGT_SLAVE,  rd: 1'b0, regno: REG_CTRL,  data: CTRL_SLV};
        PC_W'(5):  cmd = '{tgt: TGT_MASTER, rd: 1'b0, regno: REG_RXCFG,
                           data: (L2_BASE & ~16'h0017) | {13'd0, skew[2:0]}};
        PC_W'(6):  cmd = '{tgt: TGT_MASTER, rd: 1'b0, regno: REG_TXCFG,
                           data: (L3_BASE & ~16'h0017) | {13'd0, skew[5:3]}};
        PC_W'(7):  cmd = '{tgt: TGT_MASTER, rd: 1'b0, regno: REG_SHIFT,
                           data: (L4_BASE & ~16'h0003) | {14'd0, skew[7:6]}};
        PC_W'(8):  cmd = '{tgt: TGT_MASTER, rd: 1'b1, regno: REG_ERR_A, data: 16'h0000};
        PC_W'(9):  cmd = '{tgt: TGT_MASTER, rd: 1'b1, regno: REG_ERR_B, data: 16'h0000};
        PC_W'(10): cmd = '{tgt: TGT_SLAVE,  rd: 1'b1, regno: REG_ERR_A, data: 16'h0000};
        PC_W'(11): cmd = '{tgt: TGT_SLAVE,  rd: 1'b1, regno: REG_ERR_B, data: 16'h0000};
        PC_W'(12): cmd = '{tgt: TGT_BOTH,   rd: 1'b0, regno: REG_RESET, data: 16'h0001};
        default:   cmd = '{tgt: TGT_BOTH,   rd: 1'b0, regno: REG_RESET, data: 16'h0000};
      endcase
    end
  end

endmodule

// File: rtl/stereo_cfg_issue.sv
module stereo_cfg_issue
  import stereo_cfg_pkg::*;
#(
  parameter int FLAG_BIT = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  cmd_t        cmd,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [7:0]  cmd_reg,
  output logic [15:0] cmd_wdata,
  output logic        cmd_rd,
  input  logic        cmd_done,
  input  logic [15:0] cmd_rdata,
  output logic        sel_m,
  output logic        sel_s,
  output logic        fin,
  output logic        fin_flag
);

  typedef enum logic [1:0] {I_IDLE, I_REQ, I_WAIT} ist_e;

  ist_e       st_q, st_d;
  cmd_t       cmd_q;
  logic       cmd_ld;
  logic [1:0] sel_q, sel_d;
  logic       sel_ld;

  always_comb begin
    st_d   = st_q;
    sel_d  = sel_q;
    cmd_ld = 1'b0;
    sel_ld = 1'b0;
    unique case (st_q)
      I_IDLE: if (go) begin
        st_d   = I_REQ;
        cmd_ld = 1'b1;
        sel_ld = 1'b1;
        unique case (cmd.tgt)
          TGT_MASTER: sel_d = 2'b01;
          TGT_SLAVE:  sel_d = 2'b10;
          default:    sel_d = 2'b00;
        endcase
      end
      I_REQ:  if (cmd_ready) st_d = I_WAIT;
      I_WAIT: if (cmd_done) begin
        st_d   = I_IDLE;
        sel_ld = 1'b1;
        sel_d  = SEL_IDLE;
      end
      default: st_d = I_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= I_IDLE;
      cmd_q <= '0;
      sel_q <= SEL_IDLE;
    end else begin
      st_q <= st_d;
      if (cmd_ld) cmd_q <= cmd;
      if (sel_ld) sel_q <= sel_d;
    end
  end

  assign cmd_valid = (st_q == I_REQ);
  assign cmd_reg   = cmd_q.regno;
  assign cmd_wdata = cmd_q.data;
  assign cmd_rd    = cmd_q.rd;
  assign sel_m     = sel_q[1];
  assign sel_s     = sel_q[0];
  assign fin       = (st_q == I_WAIT) && cmd_done;
  assign fin_flag  = fin && cmd_q.rd && cmd_rdata[FLAG_BIT];

endmodule

// File: rtl/stereo_cfg_ctrl.sv
module stereo_cfg_ctrl #(
  parameter int NUM_EXTRA = 4,
  parameter int NUM_SKEW  = 4,
  parameter int MAX_TRIES = 8,
  parameter int PC_W      = 5,
  parameter int SK_W      = 2,
  parameter int TR_W      = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            fin,
  input  logic            fin_flag,
  output logic            go,
  output logic [PC_W-1:0] pc,
  output logic [SK_W-1:0] skew_idx,
  output logic            busy,
  output logic            done,
  output logic            fail
);

  localparam logic [PC_W-1:0] LOOP_PC = PC_W'(NUM_EXTRA + 8);
  localparam logic [PC_W-1:0] LAST_PC = PC_W'(NUM_EXTRA + 16);
  localparam logic [SK_W-1:0] SK_LAST = SK_W'(NUM_SKEW - 1);
  localparam logic [TR_W-1:0] TR_LAST = TR_W'(MAX_TRIES - 1);

  typedef enum logic [2:0] {C_IDLE, C_ISSUE, C_WAIT, C_DONE, C_FAIL} cst_e;

  cst_e            st_q, st_d;
  logic [PC_W-1:0] pc_q, pc_d;
  logic [SK_W-1:0] sk_q, sk_d;
  logic [TR_W-1:0] tr_q, tr_d;
  logic            err_q, err_d;
  logic            err_any;

  always_comb begin
    st_d    = st_q;
    pc_d    = pc_q;
    sk_d    = sk_q;
    tr_d    = tr_q;
    err_d   = err_q;
    err_any = err_q | fin_flag;
    unique case (st_q)
      C_IDLE, C_DONE, C_FAIL: if (start) begin
        st_d  = C_ISSUE;
        pc_d  = '0;
        sk_d  = '0;
        tr_d  = '0;
        err_d = 1'b0;
      end
      C_ISSUE: st_d = C_WAIT;
      C_WAIT: if (fin) begin
        err_d = err_any;
        if (pc_q == LAST_PC) begin
          if (!err_any) begin
            st_d = C_DONE;
          end else if (tr_q == TR_LAST) begin
            st_d = C_FAIL;
          end else begin
            st_d  = C_ISSUE;
            pc_d  = LOOP_PC;
            tr_d  = tr_q + TR_W'(1);
            sk_d  = (sk_q == SK_LAST) ? '0 : sk_q + SK_W'(1);
            err_d = 1'b0;
          end
        end else begin
          st_d = C_ISSUE;
          pc_d = pc_q + PC_W'(1);
        end
      end
      default: st_d = C_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= C_IDLE;
      pc_q  <= '0;
      sk_q  <= '0;
      tr_q  <= '0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      pc_q  <= pc_d;
      sk_q  <= sk_d;
      tr_q  <= tr_d;
      err_q <= err_d;
    end
  end

  assign go       = (st_q == C_ISSUE);
  assign pc       = pc_q;
  assign skew_idx = sk_q;
  assign busy     = (st_q == C_ISSUE) || (st_q == C_WAIT);
  assign done     = (st_q == C_DONE);
  assign fail     = (st_q == C_FAIL);

endmodule

// File: rtl/stereo_cfg_seq.sv
module stereo_cfg_seq
  import stereo_cfg_pkg::*;
#(
  parameter int NUM_EXTRA = 4,
  parameter int NUM_SKEW  = 4,
  parameter int MAX_TRIES = 8,
  parameter int FLAG_BIT  = 0,
  parameter logic [6:0]  DEV_ADDR = 7'h48,
  parameter logic [NUM_EXTRA*24-1:0] EXTRA_TAB = 96'h06_002D_05_005E_04_02F0_03_01E0,
  parameter logic [NUM_SKEW*8-1:0]   SKEW_TAB  = 32'hC9_52_1B_00,
  parameter logic [15:0] B1_BASE  = 16'h001B,
  parameter logic [15:0] S07_BASE = 16'h0388,
  parameter logic [15:0] L2_BASE  = 16'h0014,
  parameter logic [15:0] L3_BASE  = 16'h0014,
  parameter logic [15:0] L4_BASE  = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [6:0]  cmd_addr,
  output logic [7:0]  cmd_reg,
  output logic [15:0] cmd_wdata,
  output logic        cmd_rd,
  input  logic        cmd_done,
  input  logic [15:0] cmd_rdata,
  output logic        sel_m,
  output logic        sel_s,
  output logic        busy,
  output logic        done,
  output logic        fail
);

  localparam int PC_W = $clog2(NUM_EXTRA + 17);
  localparam int SK_W = (NUM_SKEW > 1) ? $clog2(NUM_SKEW) : 1;
  localparam int TR_W = $clog2(MAX_TRIES + 1);

  logic [1:0]      rst_sync;
  logic            rst_int_n;
  logic            go, fin, fin_flag;
  logic [PC_W-1:0] pc;
  logic [SK_W-1:0] skew_idx;
  cmd_t            cur_cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  stereo_cfg_ctrl #(
    .NUM_EXTRA(NUM_EXTRA), .NUM_SKEW(NUM_SKEW), .MAX_TRIES(MAX_TRIES),
    .PC_W(PC_W), .SK_W(SK_W), .TR_W(TR_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .start(start), .fin(fin), .fin_flag(fin_flag),
    .go(go), .pc(pc), .skew_idx(skew_idx), .busy(busy), .done(done), .fail(fail)
  );

  stereo_cfg_rom #(
    .NUM_EXTRA(NUM_EXTRA), .NUM_SKEW(NUM_SKEW), .PC_W(PC_W), .SK_W(SK_W),
    .EXTRA_TAB(EXTRA_TAB), .SKEW_TAB(SKEW_TAB), .B1_BASE(B1_BASE),
    .S07_BASE(S07_BASE), .L2_BASE(L2_BASE), .L3_BASE(L3_BASE), .L4_BASE(L4_BASE)
  ) u_rom (
    .pc(pc), .skew_idx(skew_idx), .cmd(cur_cmd)
  );

  stereo_cfg_issue #(.FLAG_BIT(FLAG_BIT)) u_issue (
    .clk(clk), .rst_n(rst_int_n), .go(go), .cmd(cur_cmd),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_reg(cmd_reg),
    .cmd_wdata(cmd_wdata), .cmd_rd(cmd_rd), .cmd_done(cmd_done),
    .cmd_rdata(cmd_rdata), .sel_m(sel_m), .sel_s(sel_s),
    .fin(fin), .fin_flag(fin_flag)
  );

  assign cmd_addr = DEV_ADDR;

endmodule

// File: rtl/stereo_cfg_seq_chk.sv
module stereo_cfg_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [7:0]  cmd_reg,
  input logic [15:0] cmd_wdata,
  input logic        cmd_rd,
  input logic        cmd_done,
  input logic        sel_m,
  input logic        sel_s,
  input logic        busy,
  input logic        done,
  input logic        fail
);

  logic pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       pend <= 1'b0;
    else if (cmd_valid && cmd_ready)  pend <= 1'b1;
    else if (cmd_done)                pend <= 1'b0;
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !pend); // R6
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> $stable({sel_m, sel_s})); // R2
  AST_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && !pend) |-> ({sel_m, sel_s} == 2'b11)); // R1
  AST_READ_INDIV: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_rd) |-> (sel_m != sel_s)); // R3
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> cmd_valid); // R7
  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> ($stable(cmd_reg) && $stable(cmd_wdata) && $stable(cmd_rd))); // R7
  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail)); // R12
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!done && !fail)); // R11
  AST_END_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |-> !cmd_valid); // R11

endmodule

bind stereo_cfg_seq stereo_cfg_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata), .cmd_rd(cmd_rd), .cmd_done(cmd_done),
  .sel_m(sel_m), .sel_s(sel_s), .busy(busy), .done(done), .fail(fail)
);

// File: tb/stereo_cfg_seq_bench.sv
module stereo_cfg_seq_bench;

  localparam int NE = 2;
  localparam int NS = 3;
  localparam int NT = 4;
  localparam logic [6:0]  ADDR = 7'h5C;
  localparam logic [47:0] XTAB = {8'h06, 16'h002D, 8'h01, 16'h01E0};
  localparam logic [23:0] STAB = {8'hA7, 8'h5B, 8'h00};
  localparam int B1 = 16'h00FF, S07 = 16'h03FF, L2 = 16'h00FF, L3 = 16'h00FF, L4 = 16'h00FF;

  logic clk = 1'b0;
  logic rst_n, start, cmd_valid, cmd_ready, cmd_rd, cmd_done, sel_m, sel_s, busy, done, fail;
  logic [6:0]  cmd_addr;
  logic [7:0]  cmd_reg;
  logic [15:0] cmd_wdata, cmd_rdata;

  int nchk = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  stereo_cfg_seq #(
    .NUM_EXTRA(NE), .NUM_SKEW(NS), .MAX_TRIES(NT), .FLAG_BIT(0), .DEV_ADDR(ADDR),
    .EXTRA_TAB(XTAB), .SKEW_TAB(STAB), .B1_BASE(16'(B1)), .S07_BASE(16'(S07)),
    .L2_BASE(16'(L2)), .L3_BASE(16'(L3)), .L4_BASE(16'(L4))
  ) u_stereo_cfg_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata), .cmd_rd(cmd_rd),
    .cmd_done(cmd_done), .cmd_rdata(cmd_rdata), .sel_m(sel_m), .sel_s(sel_s),
    .busy(busy), .done(done), .fail(fail)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Target codes: 0 broadcast -> {sel_m,sel_s}=00, 1 master -> 01, 2 slave -> 10 (R2)
  task automatic serve(input int tg, input bit rd, input int rg, input int wd, input bit flag,
                       input int lat, input int dly, input string req);
    logic [1:0]  esel;
    logic [33:0] got, exp;
    esel = (tg == 0) ? 2'b00 : (tg == 1) ? 2'b01 : 2'b10;
    while (!cmd_valid) @(negedge clk);
    got = {sel_m, sel_s, cmd_rd, cmd_reg, cmd_wdata, cmd_addr};
    exp = {esel, rd, 8'(rg), 16'(wd), ADDR};
    chk(got == exp, req, 64'(got), 64'(exp));
    if (rd) chk(sel_m != sel_s, "R3", {62'd0, sel_m, sel_s}, 64'd1);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      chk(cmd_valid && ({sel_m, sel_s, cmd_rd, cmd_reg, cmd_wdata, cmd_addr} == exp), "R7",
          {29'd0, cmd_valid, sel_m, sel_s, cmd_rd, cmd_reg, cmd_wdata, cmd_addr}, {29'd0, 1'b1, exp});
    end
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
    for (int i = 0; i <= dly; i++) begin
      chk(!cmd_valid && ({sel_m, sel_s} == esel), "R6", {62'd0, cmd_valid, 1'b0} | {62'd0, sel_m, sel_s}, 64'(esel));
      if (i < dly) @(negedge clk);
    end
    cmd_rdata = flag ? 16'h5A5B : 16'h5A5A;
    cmd_done = 1'b1;
    @(negedge clk);
    cmd_done = 1'b0;
    cmd_rdata = 16'h0;
  endtask

  task automatic exp_init(input int n, output int tg, output int rg, output int wd, output string req);
    req = "R4";
    if (n < 3) begin
      case (n)
        0: begin tg = 0; rg = 8'hB1; wd = B1 & ~3; end
        1: begin tg = 1; rg = 8'hB1; wd = (B1 & ~3) | 1; end
        default: begin tg = 0; rg = 8'h07; wd = (S07 & ~32'h60) | 32'h20; end
      endcase
    end else if (n < 3 + NE) begin
      tg = 0; rg = int'(XTAB[(n-3)*24+16 +: 8]); wd = int'(XTAB[(n-3)*24 +: 16]); req = "R5";
    end else begin
      case (n - 3 - NE)
        0: begin tg = 0; rg = 8'hB3; wd = L3 & ~32'h10; end
        1: begin tg = 0; rg = 8'hB2; wd = L2 & ~32'h10; end
        2: begin tg = 1; rg = 8'hB1; wd = (B1 & ~3) | 1; end
        3: begin tg = 2; rg = 8'hB1; wd = B1 & ~3; end
        default: begin tg = 2; rg = 8'h07; wd = S07 | 32'h60; end
      endcase
    end
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_all();
    int tg, rg, wd, sk, n, a;
    string req;
    rst_n = 1'b0; start = 1'b0; cmd_ready = 1'b0; cmd_done = 1'b0; cmd_rdata = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!cmd_valid && !busy && !done && !fail && {sel_m, sel_s} == 2'b11, "R1",
        {59'd0, cmd_valid, busy, done, fail, sel_m & sel_s}, 64'd1);
    for (int k = 0; k <= NT; k++) begin
      pulse_start();
      chk(busy && !done && !fail, "R13", {61'd0, busy, done, fail}, 64'd4);
      n = 0;
      for (int i = 0; i < 3 + NE + 5; i++) begin
        exp_init(i, tg, rg, wd, req);
        serve(tg, 1'b0, rg, wd, 1'b0, (k + n) % 3, n % 2, req);
        n++;
        if (k == 2 && i == 4) begin
          pulse_start();  // mid-run start must be ignored (R13)
          chk(busy, "R13", {63'd0, busy}, 64'd1);
        end
      end
      a = 0;
      forever begin
        sk = int'(STAB[(a % NS)*8 +: 8]);
        serve(1, 1'b0, 8'hB2, (L2 & ~32'h17) | (sk & 7), 1'b0, n % 3, n % 2, "R8"); n++;
        serve(1, 1'b0, 8'hB3, (L3 & ~32'h17) | ((sk >> 3) & 7), 1'b0, n % 3, n % 2, "R8"); n++;
        serve(1, 1'b0, 8'hB4, (L4 & ~3) | ((sk >> 6) & 3), 1'b0, n % 3, n % 2, "R8"); n++;
        for (int r = 0; r < 4; r++) begin
          serve((r < 2) ? 1 : 2, 1'b1, (r % 2 == 0) ? 8'hB7 : 8'hB8, 0,
                (a < k) && (r == a % 4), n % 3, n % 2, "R9");
          n++;
        end
        serve(0, 1'b0, 8'h0C, 1, 1'b0, n % 3, n % 2, "R10"); n++;
        serve(0, 1'b0, 8'h0C, 0, 1'b0, n % 3, n % 2, "R10"); n++;
        if (a >= k || a == NT - 1) break;
        a++;
      end
      if (k < NT) begin
        chk(done && !fail && !busy, "R11", {61'd0, busy, done, fail}, 64'd2);
        repeat (3) @(negedge clk);
        chk(done && !cmd_valid, "R11", {62'd0, done, cmd_valid}, 64'd2);
      end else begin
        chk(fail && !done && !busy, "R12", {61'd0, busy, done, fail}, 64'd1);
        repeat (3) @(negedge clk);
        chk(fail && !cmd_valid, "R12", {62'd0, fail, cmd_valid}, 64'd2);
      end
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual hang expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule